// File: doc/BRIEF.md
# Paired Synchronous Serial Channel Controller

This block holds two byte-wide clocked serial shift channels and decides how they are wired together. In the independent mode each channel has its own clock pin, data pin, role, clock shape and buffer. In the three fused modes, channel 0's clock pin becomes the only clock for both channels. Channel 1 is then held as a slave that is clocked internally from channel 0. The fused modes are a full-duplex pair (channel 0 sends, channel 1 receives), the same pair with channel 1 following channel 0's clock shape, and a single-data-line half-duplex variant on data pin 1.

A master channel makes one clock toggle for each pulse of the external `baud_tick` strobe. One byte takes sixteen toggles, and the most significant bit goes first. The phase bit picks the edges: with phase 0, data is sampled on the leading edge and shifted on the trailing edge; with phase 1, it is the other way round. The polarity bit sets the idle level of the clock. A receive buffer keeps the last completed byte. An unread buffer that is overwritten raises a sticky overrun flag. In the select modes, a contention request shows when a master pair sees its clock pin pulled away from idle while no transfer is running.

Top module: `sspair_top`

## Requirements
- R1: After reset, every `*_done`, `*_ovr` and `cont_irq` output is 0, both receive buffers read 0, and both clock outputs are at 0.
- R2: In independent mode (`ch1_mode`=2'b00) each channel runs on its own. A buffer write to a master channel with `pair_en`=1 shifts the byte out and back in over its own pins. The received byte is loaded into that channel's buffer, and its `done` output pulses for exactly one cycle.
- R3: The pair mode is taken from `ch1_mode`, which belongs to channel 1's clock settings: 2'b00 independent, 2'b01 duplex, 2'b10 select full-duplex, 2'b11 select half-duplex.
- R4: In duplex mode channel 1 is held as a slave and a receiver whatever its own role bits say (`sc1_oe`=0). It is clocked from channel 0's clock and uses its own polarity and phase bits. Its buffer takes the byte presented on `sd1_in`.
- R5: In duplex and select full-duplex modes, a write to channel 0's buffer starts both channels when `pair_en`=1. When `pair_en`=0 the write starts nothing: the clock does not toggle and channel 1's buffer keeps its value.
- R6: A buffer write made while a transfer is in progress is ignored, and the byte that was started is the one delivered.
- R7: In select full-duplex mode, channel 1 samples with channel 0's polarity and phase bits, whatever its own bits say.
- R8: In select half-duplex mode, only `sc0` and `sd1` are used (`sd0_oe`=0, `sc1_oe`=0). A write to channel 1's buffer starts the transfer. `ch1_tx` sets the direction of `sd1`, and channel 0's buffer is not changed.
- R9: A completion that overwrites an unread channel 1 buffer sets `ch1_ovr`. The flag stays set until a `ch1_rd` pulse clears it. A read in the same cycle as the completion counts as reading the old byte, so no overrun is raised.
- R10: `cont_irq` is 1, one cycle after the condition, when all of the following hold: a select mode, channel 0 is master, `cont_irq_en`=1, no transfer is in progress, and `sc0_in` differs from channel 0's polarity bit. Otherwise it is 0.
- R11: With phase 0, the most significant bit of a loaded byte is on the data output before the first clock edge.
- R12: A master clock rests at its polarity level, toggles once per `baud_tick` pulse during a transfer, and ends at the idle level after exactly 16 toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Shift-rate strobe for master clocks |
| pair_en | input | 1 | Allows buffer writes to start transfers |
| ch1_mode | input | 2 | Pair mode field of channel 1 clock settings |
| cont_irq_en | input | 1 | Enables the contention request |
| ch0_master | input | 1 | Channel 0 (and fused pair) is master |
| ch0_tx | input | 1 | Channel 0 transmits |
| ch0_cpol | input | 1 | Channel 0 clock idle level |
| ch0_cpha | input | 1 | Channel 0 clock phase |
| ch1_master | input | 1 | Channel 1 is master (independent mode) |
| ch1_tx | input | 1 | Channel 1 transmits |
| ch1_cpol | input | 1 | Channel 1 clock idle level |
| ch1_cpha | input | 1 | Channel 1 clock phase |
| ch0_wr | input | 1 | Channel 0 buffer write strobe |
| ch0_wdata | input | 8 | Channel 0 write data |
| ch0_rd | input | 1 | Channel 0 buffer read strobe |
| ch0_rdata | output | 8 | Channel 0 receive buffer |
| ch0_done | output | 1 | Channel 0 transfer complete pulse |
| ch0_ovr | output | 1 | Channel 0 overrun flag |
| ch1_wr | input | 1 | Channel 1 buffer write strobe |
| ch1_wdata | input | 8 | Channel 1 write data |
| ch1_rd | input | 1 | Channel 1 buffer read strobe |
| ch1_rdata | output | 8 | Channel 1 receive buffer |
| ch1_done | output | 1 | Channel 1 transfer complete pulse |
| ch1_ovr | output | 1 | Channel 1 overrun flag |
| cont_irq | output | 1 | Master contention request |
| sc0_in | input | 1 | Clock pin 0 input |
| sc0_out | output | 1 | Clock pin 0 output |
| sc0_oe | output | 1 | Clock pin 0 drive enable |
| sd0_in | input | 1 | Data pin 0 input |
| sd0_out | output | 1 | Data pin 0 output |
| sd0_oe | output | 1 | Data pin 0 drive enable |
| sc1_in | input | 1 | Clock pin 1 input |
| sc1_out | output | 1 | Clock pin 1 output |
| sc1_oe | output | 1 | Clock pin 1 drive enable |
| sd1_in | input | 1 | Data pin 1 input |
| sd1_out | output | 1 | Data pin 1 output |
| sd1_oe | output | 1 | Data pin 1 drive enable |

## Verification
Two events can fall on the same clock edge: the software read of channel 1's buffer and the completion of a new reception into it. The bench leaves one byte unread and starts a second duplex transfer. It watches for channel 0's done pulse, because in master pairs channel 1 finishes exactly one cycle later. It then drives `ch1_rd` so that the read lands on that completion edge. The expected result is the new byte in the buffer and `ch1_ovr` still clear; a third unread completion must then set the flag.

// File: rtl/sspair_pkg.sv
// Shared types for the paired serial channel controller.
// Assumes nothing beyond a synthesizable 2-state view of the fields.
package sspair_pkg;

    typedef enum logic [1:0] {
        MODE_INDEP    = 2'b00,
        MODE_DUPLEX   = 2'b01,
        MODE_SEL_FULL = 2'b10,
        MODE_SEL_HALF = 2'b11
    } pair_mode_e;

    typedef struct packed {
        logic master;
        logic tx;
        logic cpol;
        logic cpha;
    } chan_cfg_t;

endpackage

// File: rtl/sspair_chan.sv
// One serial shift channel. As master it toggles its clock on each baud
// strobe; as slave it follows transitions of sck_in. Sixteen edges move one
// byte, MSB first. Assumes sck_in is already synchronous to clk and that a
// master's baud strobe is no faster than every second cycle.
module sspair_chan
    import sspair_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_cfg_t     cfg,
    input  logic          baud_tick,
    input  logic          sck_in,
    input  logic          din,
    input  logic          ld,
    input  logic [DW-1:0] wdata,
    input  logic          go,
    input  logic          cap,
    input  logic          rd,
    output logic          sck_o,
    output logic          txd,
    output logic          busy,
    output logic          done,
    output logic          ovr,
    output logic [DW-1:0] rdata
);
    localparam int         EDGES = 2 * DW;
    localparam int         EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

    logic          busy_q, sck_q, prev_q, rbit_q, out_q, done_q;
    logic          unread_q, ovr_q;
    logic [EW-1:0] cnt_q;
    logic [DW-1:0] sr_q, rdata_q;
    logic          ev, lead, last, shin;
    logic [DW-1:0] sr_sh;

    // Edge event, leading/trailing classification and next shift value.
    always_comb begin
        ev    = busy_q & (cfg.master ? baud_tick : (sck_in != prev_q));
        lead  = cfg.master ? (sck_q == cfg.cpol) : (sck_in != cfg.cpol);
        last  = ev & (cnt_q == LAST);
        shin  = cfg.cpha ? din : rbit_q;
        sr_sh = {sr_q[DW-2:0], shin};
    end

    // Clock level: idle at polarity, toggled by master events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= sck_in;
            if (!busy_q)
                sck_q <= cfg.cpol;
            else if (ev && cfg.master)
                sck_q <= ~sck_q;
        end
    end

    // Transfer sequencing: start, edge count, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (!busy_q) begin
                cnt_q <= '0;
                if (go)
                    busy_q <= 1'b1;
            end else if (ev) begin
                cnt_q <= cnt_q + 1'b1;
                if (last)
                    busy_q <= 1'b0;
            end
        end
    end

    // Shift path: load when idle, sample/present on leading, shift on trailing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            out_q  <= 1'b0;
            rbit_q <= 1'b0;
        end else if (ld && !busy_q) begin
            sr_q  <= wdata;
            out_q <= wdata[DW-1];
        end else if (ev) begin
            if (lead) begin
                if (cfg.cpha)
                    out_q <= sr_q[DW-1];
                else
                    rbit_q <= din;
            end else begin
                sr_q <= sr_sh;
            end
        end
    end

    // Receive buffer with unread tracking and sticky overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            unread_q <= 1'b0;
            ovr_q    <= 1'b0;
        end else if (last && cap) begin
            rdata_q  <= sr_sh;
            unread_q <= 1'b1;
            ovr_q    <= (ovr_q | unread_q) & ~rd;
        end else if (rd) begin
            unread_q <= 1'b0;
            ovr_q    <= 1'b0;
        end
    end

    assign sck_o = sck_q;
    assign txd   = cfg.cpha ? out_q : sr_q[DW-1];
    assign busy  = busy_q;
    assign done  = done_q;
    assign ovr   = ovr_q;
    assign rdata = rdata_q;

    // R12: a master clock is back at idle when its completion pulse shows.
    a_r12_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && cfg.master) |-> (sck_q == cfg.cpol));

    // R9: overrun only appears on a capturing completion edge.
    a_r9_ovr_on_completion: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(last && cap));

    // R2: completion is a single-cycle pulse.
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/sspair_route.sv
// Mode router: derives each channel's effective settings, clock source,
// start and capture strobes, and the pin drive enables from the mode field.
// Assumes the mode field is static while a transfer is in progress.
module sspair_route
    import sspair_pkg::*;
(
    input  pair_mode_e mode,
    input  chan_cfg_t  cfg0,
    input  chan_cfg_t  cfg1,
    input  logic       sck0_int,
    input  logic       sc0_in,
    input  logic       sc1_in,
    input  logic       wr0,
    input  logic       wr1,
    input  logic       pair_en,
    output chan_cfg_t  eff0,
    output chan_cfg_t  eff1,
    output logic       sck_in0,
    output logic       sck_in1,
    output logic       go0,
    output logic       go1,
    output logic       cap0,
    output logic       cap1,
    output logic       sc0_oe,
    output logic       sc1_oe,
    output logic       sd0_oe,
    output logic       sd1_oe,
    output logic       paired
);
    logic shared_clk;

    // Per-mode routing of settings, clocks, starts and pin enables.
    always_comb begin
        shared_clk = cfg0.master ? sck0_int : sc0_in;
        eff0    = cfg0;
        eff1    = cfg1;
        sck_in0 = sc0_in;
        sck_in1 = sc1_in;
        go0     = wr0 & pair_en;
        go1     = wr1 & pair_en;
        cap0    = 1'b1;
        cap1    = 1'b1;
        sc0_oe  = cfg0.master;
        sc1_oe  = cfg1.master;
        sd0_oe  = cfg0.tx;
        sd1_oe  = cfg1.tx;
        paired  = 1'b1;
        unique case (mode)
            MODE_INDEP: begin
                paired = 1'b0;
            end
            MODE_DUPLEX, MODE_SEL_FULL: begin
                eff0    = '{master: cfg0.master, tx: 1'b1, cpol: cfg0.cpol, cpha: cfg0.cpha};
                eff1    = (mode == MODE_DUPLEX)
                        ? '{master: 1'b0, tx: 1'b0, cpol: cfg1.cpol, cpha: cfg1.cpha}
                        : '{master: 1'b0, tx: 1'b0, cpol: cfg0.cpol, cpha: cfg0.cpha};
                sck_in1 = shared_clk;
                go1     = wr0 & pair_en;
                sc1_oe  = 1'b0;
                sd0_oe  = 1'b1;
                sd1_oe  = 1'b0;
            end
            MODE_SEL_HALF: begin
                eff0    = '{master: cfg0.master, tx: 1'b0, cpol: cfg0.cpol, cpha: cfg0.cpha};
                eff1    = '{master: 1'b0, tx: cfg1.tx, cpol: cfg0.cpol, cpha: cfg0.cpha};
                sck_in1 = shared_clk;
                go0     = wr1 & pair_en;
                cap0    = 1'b0;
                sc1_oe  = 1'b0;
                sd0_oe  = 1'b0;
                sd1_oe  = cfg1.tx;
            end
            default: paired = 1'b0;
        endcase
    end

endmodule

// File: rtl/sspair_contend.sv
// Contention detector: in the select modes a master pair that sees its
// shared clock pin away from idle while idle itself raises a request.
// Assumes sc0_in is synchronous to clk.
module sspair_contend
    import sspair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pair_mode_e mode,
    input  logic       irq_en,
    input  logic       master,
    input  logic       cpol,
    input  logic       pair_busy,
    input  logic       sc0_in,
    output logic       irq
);
    logic sel_mode, irq_q;

    // Select modes are the two upper mode encodings.
    always_comb sel_mode = (mode == MODE_SEL_FULL) || (mode == MODE_SEL_HALF);

    // Registered contention request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= irq_en & sel_mode & master & ~pair_busy & (sc0_in != cpol);
    end

    assign irq = irq_q;

    // R10: a request never follows a cycle in which the pair was busy.
    a_r10_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !$past(pair_busy));

endmodule

// File: rtl/sspair_top.sv
// Paired serial channel controller top. Flattens the settings into the
// package structs, routes clocks and strobes per mode, and exposes the pin
// level signals. Assumes all inputs are synchronous to clk.
module sspair_top
    import sspair_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          pair_en,
    input  logic [1:0]    ch1_mode,
    input  logic          cont_irq_en,
    input  logic          ch0_master,
    input  logic          ch0_tx,
    input  logic          ch0_cpol,
    input  logic          ch0_cpha,
    input  logic          ch1_master,
    input  logic          ch1_tx,
    input  logic          ch1_cpol,
    input  logic          ch1_cpha,
    input  logic          ch0_wr,
    input  logic [DW-1:0] ch0_wdata,
    input  logic          ch0_rd,
    output logic [DW-1:0] ch0_rdata,
    output logic          ch0_done,
    output logic          ch0_ovr,
    input  logic          ch1_wr,
    input  logic [DW-1:0] ch1_wdata,
    input  logic          ch1_rd,
    output logic [DW-1:0] ch1_rdata,
    output logic          ch1_done,
    output logic          ch1_ovr,
    output logic          cont_irq,
    input  logic          sc0_in,
    output logic          sc0_out,
    output logic          sc0_oe,
    input  logic          sd0_in,
    output logic          sd0_out,
    output logic          sd0_oe,
    input  logic          sc1_in,
    output logic          sc1_out,
    output logic          sc1_oe,
    input  logic          sd1_in,
    output logic          sd1_out,
    output logic          sd1_oe
);
    pair_mode_e mode;
    chan_cfg_t  cfg0, cfg1, eff0, eff1;
    logic       sck_in0, sck_in1, go0, go1, cap0, cap1, paired;
    logic       busy0, busy1;

    // Pack flat settings into structs.
    always_comb begin
        mode = pair_mode_e'(ch1_mode);
        cfg0 = '{master: ch0_master, tx: ch0_tx, cpol: ch0_cpol, cpha: ch0_cpha};
        cfg1 = '{master: ch1_master, tx: ch1_tx, cpol: ch1_cpol, cpha: ch1_cpha};
    end

    sspair_route u_route (
        .mode     (mode),
        .cfg0     (cfg0),
        .cfg1     (cfg1),
        .sck0_int (sc0_out),
        .sc0_in   (sc0_in),
        .sc1_in   (sc1_in),
        .wr0      (ch0_wr),
        .wr1      (ch1_wr),
        .pair_en  (pair_en),
        .eff0     (eff0),
        .eff1     (eff1),
        .sck_in0  (sck_in0),
        .sck_in1  (sck_in1),
        .go0      (go0),
        .go1      (go1),
        .cap0     (cap0),
        .cap1     (cap1),
        .sc0_oe   (sc0_oe),
        .sc1_oe   (sc1_oe),
        .sd0_oe   (sd0_oe),
        .sd1_oe   (sd1_oe),
        .paired   (paired)
    );

    sspair_chan #(.DW(DW)) u_ch0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (eff0),
        .baud_tick (baud_tick),
        .sck_in    (sck_in0),
        .din       (sd0_in),
        .ld        (ch0_wr),
        .wdata     (ch0_wdata),
        .go        (go0),
        .cap       (cap0),
        .rd        (ch0_rd),
        .sck_o     (sc0_out),
        .txd       (sd0_out),
        .busy      (busy0),
        .done      (ch0_done),
        .ovr       (ch0_ovr),
        .rdata     (ch0_rdata)
    );

    sspair_chan #(.DW(DW)) u_ch1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (eff1),
        .baud_tick (baud_tick),
        .sck_in    (sck_in1),
        .din       (sd1_in),
        .ld        (ch1_wr),
        .wdata     (ch1_wdata),
        .go        (go1),
        .cap       (cap1),
        .rd        (ch1_rd),
        .sck_o     (sc1_out),
        .txd       (sd1_out),
        .busy      (busy1),
        .done      (ch1_done),
        .ovr       (ch1_ovr),
        .rdata     (ch1_rdata)
    );

    sspair_contend u_contend (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .irq_en    (cont_irq_en),
        .master    (ch0_master),
        .cpol      (ch0_cpol),
        .pair_busy (busy0),
        .sc0_in    (sc0_in),
        .irq       (cont_irq)
    );

    // R4: in a fused master pair, channel 1 completes one cycle after channel 0.
    a_r4_slave_lags_master: assert property (@(posedge clk) disable iff (!rst_n)
        (paired && ch0_master && ch1_done) |-> $past(ch0_done));

    // R5: a fused master pair starts both channels on the same edge.
    a_r5_pair_starts_together: assert property (@(posedge clk) disable iff (!rst_n)
        (paired && ch0_master && $rose(busy0)) |-> busy1);

endmodule

// File: tb/sim_sspair_top.sv
module sim_sspair_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic pair_en = 1'b1;
    logic [1:0] ch1_mode = 2'b00;
    logic cont_irq_en = 1'b0;
    logic ch0_master = 1'b0, ch0_tx = 1'b0, ch0_cpol = 1'b0, ch0_cpha = 1'b0;
    logic ch1_master = 1'b0, ch1_tx = 1'b0, ch1_cpol = 1'b0, ch1_cpha = 1'b0;
    logic ch0_wr = 1'b0, ch0_rd = 1'b0, ch1_wr = 1'b0, ch1_rd = 1'b0;
    logic [DW-1:0] ch0_wdata = '0, ch1_wdata = '0;
    logic [DW-1:0] ch0_rdata, ch1_rdata;
    logic ch0_done, ch0_ovr, ch1_done, ch1_ovr, cont_irq;
    logic sc0_in, sc0_out, sc0_oe, sd0_in, sd0_out, sd0_oe;
    logic sc1_in, sc1_out, sc1_oe, sd1_in, sd1_out, sd1_oe;

    logic sc0_drv = 1'b0, sc1_drv = 1'b0, d0_lvl = 1'b0, d1_lvl = 1'b0;
    int   src0 = 0;   // 0 constant, 1 loop sd0_out
    int   src1 = 0;   // 0 constant, 1 loop sd1_out, 2 from sd0_out
    int   checks = 0, errors = 0;
    int   toggles = 0;
    logic sc0_prev = 1'b0;
    int   bdiv = 0;

    assign sc0_in = sc0_drv;
    assign sc1_in = sc1_drv;
    assign sd0_in = (src0 == 1) ? sd0_out : d0_lvl;
    assign sd1_in = (src1 == 1) ? sd1_out : (src1 == 2) ? sd0_out : d1_lvl;

    sspair_top #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .pair_en(pair_en),
        .ch1_mode(ch1_mode), .cont_irq_en(cont_irq_en),
        .ch0_master(ch0_master), .ch0_tx(ch0_tx), .ch0_cpol(ch0_cpol), .ch0_cpha(ch0_cpha),
        .ch1_master(ch1_master), .ch1_tx(ch1_tx), .ch1_cpol(ch1_cpol), .ch1_cpha(ch1_cpha),
        .ch0_wr(ch0_wr), .ch0_wdata(ch0_wdata), .ch0_rd(ch0_rd), .ch0_rdata(ch0_rdata),
        .ch0_done(ch0_done), .ch0_ovr(ch0_ovr),
        .ch1_wr(ch1_wr), .ch1_wdata(ch1_wdata), .ch1_rd(ch1_rd), .ch1_rdata(ch1_rdata),
        .ch1_done(ch1_done), .ch1_ovr(ch1_ovr), .cont_irq(cont_irq),
        .sc0_in(sc0_in), .sc0_out(sc0_out), .sc0_oe(sc0_oe),
        .sd0_in(sd0_in), .sd0_out(sd0_out), .sd0_oe(sd0_oe),
        .sc1_in(sc1_in), .sc1_out(sc1_out), .sc1_oe(sc1_oe),
        .sd1_in(sd1_in), .sd1_out(sd1_out), .sd1_oe(sd1_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Baud strobe every fourth cycle, driven away from the active edge.
    always @(negedge clk) begin
        bdiv = (bdiv + 1) % 4;
        baud_tick = (bdiv == 0);
    end

    // Count toggles of clock output 0.
    always @(negedge clk) begin
        if (sc0_out !== sc0_prev) toggles = toggles + 1;
        sc0_prev = sc0_out;
    end

    function automatic logic [DW-1:0] exp_rx(input int path, input logic [DW-1:0] sent,
                                             input logic lvl);
        if (path == 0) return sent;
        return {DW{lvl}};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic m0, t0, p0, h0,
                           input logic m1, t1, p1, h1);
        @(negedge clk);
        ch1_mode = m;
        ch0_master = m0; ch0_tx = t0; ch0_cpol = p0; ch0_cpha = h0;
        ch1_master = m1; ch1_tx = t1; ch1_cpol = p1; ch1_cpha = h1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr0(input logic [DW-1:0] b);
        @(negedge clk); ch0_wr = 1'b1; ch0_wdata = b;
        @(negedge clk); ch0_wr = 1'b0;
    endtask

    task automatic wr1(input logic [DW-1:0] b);
        @(negedge clk); ch1_wr = 1'b1; ch1_wdata = b;
        @(negedge clk); ch1_wr = 1'b0;
    endtask

    task automatic rd_both();
        @(negedge clk); ch0_rd = 1'b1; ch1_rd = 1'b1;
        @(negedge clk); ch0_rd = 1'b0; ch1_rd = 1'b0;
    endtask

    // Wait until the chosen done outputs have each pulsed; counts pulses seen.
    task automatic wait_done(input bit w0, input bit w1, output bit ok, output int p1);
        bit s0 = !w0, s1 = !w1;
        ok = 0; p1 = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (ch0_done) s0 = 1;
            if (ch1_done) begin s1 = 1; p1++; end
            if (s0 && s1) begin ok = 1; break; end
        end
        @(negedge clk);
        if (ch1_done) p1++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        int pulses, t0c;
        logic [DW-1:0] a, b, c, held;
        logic p, h;
        void'($urandom(32'd2718));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 done0", ch0_done, 0); chk("R1 done1", ch1_done, 0);
        chk("R1 ovr", {ch0_ovr, ch1_ovr}, 0); chk("R1 irq", cont_irq, 0);
        chk("R1 rdata", {ch0_rdata, ch1_rdata}, 0); chk("R1 sck", {sc0_out, sc1_out}, 0);

        // R2/R3: independent mode, both masters in loopback, concurrent
        src0 = 1; src1 = 1;
        for (int k = 0; k < 6; k++) begin
            a = DW'($urandom); b = DW'($urandom);
            set_cfg(2'b00, 1, 1, k[0], k[1], 1, 1, k[1], k[0]);
            @(negedge clk); ch0_wr = 1; ch0_wdata = a; ch1_wr = 1; ch1_wdata = b;
            @(negedge clk); ch0_wr = 0; ch1_wr = 0;
            wait_done(1, 1, ok, pulses);
            chk("R2 both complete", ok, 1);
            chk("R2 single done pulse", pulses, 1);
            chk("R2 ch0 rx", ch0_rdata, exp_rx(0, a, 0));
            chk("R2 ch1 rx", ch1_rdata, exp_rx(0, b, 0));
            rd_both();
        end

        // R11/R12: MSB before first edge, idle level, 16 toggles
        set_cfg(2'b00, 1, 1, 1, 0, 0, 0, 0, 0);
        chk("R12 idle level", sc0_out, 1);
        t0c = toggles;
        wr0(8'h96);
        chk("R11 msb first", sd0_out, 1);
        wait_done(1, 0, ok, pulses);
        chk("R12 toggle count", toggles - t0c, 16);
        chk("R12 back to idle", sc0_out, 1);
        rd_both();

        // R3/R4/R7: random fused full-duplex transfers, ch1 receives sd0 stream
        src0 = 0; src1 = 2;
        for (int k = 0; k < 30; k++) begin
            int md = ($urandom % 2) + 1;
            p = 1'($urandom); h = 1'($urandom);
            a = DW'($urandom);
            if (md == 1) set_cfg(2'(md), 1, 0, p, h, 1'($urandom), 1'($urandom), p, h);
            else         set_cfg(2'(md), 1, 0, p, h, 1'($urandom), 1'($urandom), ~p, ~h);
            chk("R4 ch1 clock pin undriven", sc1_oe, 0);
            wr0(a);
            wait_done(1, 1, ok, pulses);
            chk(md == 1 ? "R4 duplex rx" : "R7 select-full rx", ch1_rdata, exp_rx(0, a, 0));
            rd_both();
        end

        // R4: duplex pair as slave on an external clock
        set_cfg(2'b01, 0, 0, 0, 0, 1, 1, 0, 0);
        sc0_drv = 0;
        a = 8'h5B;
        wr0(a);
        for (int i = 0; i < 16; i++) begin
            repeat (3) @(negedge clk);
            sc0_drv = ~sc0_drv;
        end
        repeat (4) @(negedge clk);
        chk("R4 slave pair rx", ch1_rdata, exp_rx(0, a, 0));
        chk("R4 slave pin", sc0_oe, 0);
        rd_both();

        // R5: disabled pair does not start
        set_cfg(2'b01, 1, 0, 0, 0, 0, 0, 0, 0);
        held = ch1_rdata;
        pair_en = 0;
        t0c = toggles;
        wr0(8'hC3);
        repeat (100) @(negedge clk);
        chk("R5 no toggles when disabled", toggles - t0c, 0);
        chk("R5 buffer kept", ch1_rdata, held);
        pair_en = 1;

        // R6: write during transfer ignored
        a = 8'h3A; b = 8'hE1;
        wr0(a);
        repeat (12) @(negedge clk);
        wr0(b);
        wait_done(1, 1, ok, pulses);
        chk("R6 first byte kept", ch1_rdata, a);
        rd_both();

        // R9: overrun, and read coinciding with completion
        wr0(8'h11);
        wait_done(1, 1, ok, pulses);
        chk("R9 no ovr after first", ch1_ovr, 0);
        wr0(8'h22);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (ch0_done) break;
        end
        ch1_rd = 1;
        @(negedge clk); ch1_rd = 0;
        chk("R9 same-cycle read no ovr", ch1_ovr, 0);
        chk("R9 same-cycle new data", ch1_rdata, 8'h22);
        wr0(8'h33);
        wait_done(1, 1, ok, pulses);
        chk("R9 ovr set", ch1_ovr, 1);
        repeat (5) @(negedge clk);
        chk("R9 ovr sticky", ch1_ovr, 1);
        rd_both();
        chk("R9 ovr cleared", ch1_ovr, 0);

        // R8: select half-duplex receive and transmit on sd1
        held = ch0_rdata;
        src1 = 0; d1_lvl = 1;
        set_cfg(2'b11, 1, 1, 0, 1, 1, 0, 1, 0);
        chk("R8 sd0 undriven", sd0_oe, 0);
        chk("R8 sc1 undriven", sc1_oe, 0);
        wr1(8'h00);
        wait_done(1, 1, ok, pulses);
        chk("R8 half rx", ch1_rdata, exp_rx(1, 8'h00, 1));
        chk("R8 ch0 buffer unchanged", ch0_rdata, held);
        rd_both();
        src1 = 1;
        set_cfg(2'b11, 1, 0, 1, 0, 0, 1, 0, 1);
        chk("R8 sd1 driven when tx", sd1_oe, 1);
        wr1(8'hA5);
        wait_done(1, 1, ok, pulses);
        chk("R8 half tx loop", ch1_rdata, exp_rx(0, 8'hA5, 0));
        rd_both();

        // R10: contention request
        set_cfg(2'b10, 1, 0, 0, 0, 0, 0, 0, 0);
        cont_irq_en = 1;
        @(negedge clk); sc0_drv = 1;
        @(negedge clk);
        chk("R10 contention seen", cont_irq, 1);
        cont_irq_en = 0;
        @(negedge clk);
        chk("R10 disabled", cont_irq, 0);
        cont_irq_en = 1;
        ch1_mode = 2'b00;
        @(negedge clk); @(negedge clk);
        chk("R10 not in independent mode", cont_irq, 0);
        sc0_drv = 0; cont_irq_en = 0;
        repeat (2) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule